// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This block holds the protection state of a byte-addressed serial memory and decides, byte by byte, whether a write may land. It keeps a volatile write-enable flag and three persistent control bits. Two block-protect bits select a protected upper region of the array. A pin-lock enable bit decides whether the active-low write-protect pin may lock the status register.

The serial engine sends single-cycle strobes to the unit: enable, disable, a completed status-register write carrying its data byte, and a completed memory byte write. The engine reads back the formatted status byte. For every data byte it presents the target address and samples a combinational write permit. Serial shifting and real nonvolatile storage are outside the block. Reset defaults stand in for the persistent bits.

Top module: `wp_guard`

## Requirements
- R1: After a synchronous reset the status byte reads 0x00 and the memory-write permit is 0.
- R2: The status byte is formed as bit7 = pin-lock enable, bit3 = block-protect high, bit2 = block-protect low, bit1 = write-enable flag. Bits 6:4 and bit0 always read 0.
- R3: An enable strobe sets the write-enable flag on the next clock and a disable strobe clears it. When both arrive in the same cycle, clearing wins.
- R4: An accepted status write loads bit7, bit3 and bit2 from the data byte. All other data bits are ignored, and data bit1 never changes the write-enable flag.
- R5: Every completed status write clears the write-enable flag, whether or not it was accepted.
- R6: Every completed memory byte write clears the write-enable flag.
- R7: While the write-enable flag is 0, a status write leaves bits 7, 3 and 2 unchanged and the permit is 0 at every address.
- R8: With the flag set, a status write is rejected only when the pin-lock enable is 1 and the pin is low. With the pin-lock enable at 0 the pin level has no effect on status writes.
- R9: Block-protect decode: 00 protects nothing, 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF, 11 protects every address. The permit is 1 only when the flag is set and the address is unprotected.
- R10: The write-protect pin never changes the memory-write permit.
- R11: The permit follows a change of address in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_wel_i | input | 1 | Enable-writes strobe |
| clr_wel_i | input | 1 | Disable-writes strobe |
| sr_wr_i | input | 1 | Completed status-register write strobe |
| sr_data_i | input | 8 | Data byte of the status write |
| mem_wr_done_i | input | 1 | Completed memory byte write strobe |
| addr_i | input | ADDR_W | Address of the current data byte |
| wp_n_i | input | 1 | Active-low write-protect pin |
| status_o | output | 8 | Formatted status byte |
| mem_wr_ok_o | output | 1 | Memory-write permit for addr_i |

## Verification
The bench builds the unit with the default 11-bit address. This places the decode boundaries at 0x3FF/0x400 and 0x5FF/0x600, with the top address at 0x7FF. Each block-protect setting is tried on both sides of its boundary. The pin is driven low and high under both values of the pin-lock enable. Status writes are issued with the flag clear, with the pin locking, and with data bits outside the stored fields set.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int STATUS_W = 8;

    typedef struct packed {
        logic       lock_en;
        logic [1:0] blk;
    } wp_cfg_t;

    localparam wp_cfg_t CFG_RESET = '{lock_en: 1'b0, blk: 2'b00};

    function automatic logic [STATUS_W-1:0] fmt_status(wp_cfg_t cfg, logic wel);
        return {cfg.lock_en, 3'b000, cfg.blk, wel, 1'b0};
    endfunction

    // top2 holds the two most significant address bits
    function automatic logic region_locked(logic [1:0] blk, logic [1:0] top2);
        case (blk)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/wp_latch.sv
module wp_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic sr_done_i,
    input  logic mem_done_i,
    output logic wel_o
);
    logic drop;
    assign drop = clr_i | sr_done_i | mem_done_i;

    always_ff @(posedge clk) begin
        if (rst)
            wel_o <= 1'b0;
        else if (drop)
            wel_o <= 1'b0;
        else if (set_i)
            wel_o <= 1'b1;
    end
endmodule

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
    import wp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sr_wr_i,
    input  logic [STATUS_W-1:0] data_i,
    input  logic                wel_i,
    input  logic                wp_n_i,
    output wp_cfg_t             cfg_o
);
    logic    accept;
    wp_cfg_t incoming;
    logic    unused_bits;

    assign accept      = sr_wr_i & wel_i & ~(cfg_o.lock_en & ~wp_n_i);
    assign incoming    = '{lock_en: data_i[7], blk: data_i[3:2]};
    assign unused_bits = ^{data_i[6:4], data_i[1:0]};

    always_ff @(posedge clk) begin
        if (rst)
            cfg_o <= CFG_RESET;
        else if (accept)
            cfg_o <= incoming;
    end
endmodule

// File: rtl/wp_permit.sv
module wp_permit
    import wp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              wel_i,
    input  logic [1:0]        blk_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ok_o
);
    localparam int TOP = ADDR_W - 1;

    logic [1:0] top2;
    assign top2 = addr_i[TOP -: 2];
    assign ok_o = wel_i & ~region_locked(blk_i, top2);
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_wel_i,
    input  logic                clr_wel_i,
    input  logic                sr_wr_i,
    input  logic [STATUS_W-1:0] sr_data_i,
    input  logic                mem_wr_done_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wp_n_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                mem_wr_ok_o
);
    logic    wel;
    wp_cfg_t cfg;

    wp_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_wel_i),
        .clr_i      (clr_wel_i),
        .sr_done_i  (sr_wr_i),
        .mem_done_i (mem_wr_done_i),
        .wel_o      (wel)
    );

    wp_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .sr_wr_i (sr_wr_i),
        .data_i  (sr_data_i),
        .wel_i   (wel),
        .wp_n_i  (wp_n_i),
        .cfg_o   (cfg)
    );

    wp_permit #(.ADDR_W(ADDR_W)) u_permit (
        .wel_i  (wel),
        .blk_i  (cfg.blk),
        .addr_i (addr_i),
        .ok_o   (mem_wr_ok_o)
    );

    assign status_o = fmt_status(cfg, wel);
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       set_wel_i,
    input logic       clr_wel_i,
    input logic       sr_wr_i,
    input logic       mem_wr_done_i,
    input logic       wp_n_i,
    input logic [7:0] status_o,
    input logic       mem_wr_ok_o
);
    logic [2:0] kept;
    assign kept = {status_o[7], status_o[3:2]};

    p_zero_bits_r2: assert property (@(posedge clk) disable iff (rst)
        status_o[6:4] == 3'b000 && status_o[0] == 1'b0);

    p_set_wel_r3: assert property (@(posedge clk) disable iff (rst)
        set_wel_i && !clr_wel_i && !sr_wr_i && !mem_wr_done_i |=> status_o[1]);

    p_clr_wins_r3: assert property (@(posedge clk) disable iff (rst)
        clr_wel_i |=> !status_o[1]);

    p_sr_clears_wel_r5: assert property (@(posedge clk) disable iff (rst)
        sr_wr_i |=> !status_o[1]);

    p_mem_clears_wel_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr_done_i |=> !status_o[1]);

    p_nowel_hold_r7: assert property (@(posedge clk) disable iff (rst)
        sr_wr_i && !status_o[1] |=> $stable(kept));

    p_nowel_no_permit_r7: assert property (@(posedge clk) disable iff (rst)
        !status_o[1] |-> !mem_wr_ok_o);

    p_pin_lock_r8: assert property (@(posedge clk) disable iff (rst)
        sr_wr_i && status_o[7] && !wp_n_i |=> $stable(kept));

    p_all_locked_r9: assert property (@(posedge clk) disable iff (rst)
        status_o[3:2] == 2'b11 |-> !mem_wr_ok_o);
endmodule

bind wp_guard wp_guard_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .set_wel_i     (set_wel_i),
    .clr_wel_i     (clr_wel_i),
    .sr_wr_i       (sr_wr_i),
    .mem_wr_done_i (mem_wr_done_i),
    .wp_n_i        (wp_n_i),
    .status_o      (status_o),
    .mem_wr_ok_o   (mem_wr_ok_o)
);

// File: tb/wp_guard_bench.sv
`timescale 1ns/1ps
module wp_guard_bench;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          set_wel = 1'b0, clr_wel = 1'b0, sr_wr = 1'b0, mem_done = 1'b0;
    logic [7:0]    sr_data = 8'h00;
    logic [AW-1:0] addr = '0;
    logic          wp_n = 1'b1;
    logic [7:0]    status;
    logic          mem_ok;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [8:0] q_exp[$];
    string      q_tag[$];

    // reference state
    logic       m_wel = 1'b0, m_lock = 1'b0;
    logic [1:0] m_blk = 2'b00;

    always #4 clk = ~clk;

    wp_guard #(.ADDR_W(AW)) u_wp_guard (
        .clk(clk), .rst(rst), .set_wel_i(set_wel), .clr_wel_i(clr_wel),
        .sr_wr_i(sr_wr), .sr_data_i(sr_data), .mem_wr_done_i(mem_done),
        .addr_i(addr), .wp_n_i(wp_n), .status_o(status), .mem_wr_ok_o(mem_ok)
    );

    function automatic logic ref_ok(logic [AW-1:0] a);
        logic prot;
        case (m_blk)
            2'b00:   prot = 1'b0;
            2'b01:   prot = a >= 11'h600;
            2'b10:   prot = a >= 11'h400;
            default: prot = 1'b1;
        endcase
        return m_wel && !prot;
    endfunction

    task automatic step(input logic s, input logic c, input logic w, input logic [7:0] d,
                        input logic m, input logic [AW-1:0] a, input logic pin, input string tag);
        @(negedge clk);
        set_wel = s; clr_wel = c; sr_wr = w; sr_data = d; mem_done = m; addr = a; wp_n = pin;
        if (w && m_wel && !(m_lock && !pin)) begin
            m_lock = d[7];
            m_blk  = d[3:2];
        end
        if (c || w || m) m_wel = 1'b0;
        else if (s)      m_wel = 1'b1;
        q_exp.push_back({m_lock, 3'b000, m_blk, m_wel, 1'b0, ref_ok(a)});
        q_tag.push_back(tag);
    endtask

    task automatic idle(input logic [AW-1:0] a, input logic pin, input string tag);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, a, pin, tag);
    endtask

    // same-cycle permit check after an address change
    task automatic peek(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        set_wel = 0; clr_wel = 0; sr_wr = 0; mem_done = 0;
        addr = a;
        #1;
        checks++;
        if (mem_ok !== ref_ok(a)) begin
            fails++;
            $display("FAIL %s permit at %03h: got %b expected %b", tag, a, mem_ok, ref_ok(a));
        end
    endtask

    // monitor: compare each expected item after the edge that produces it
    always @(posedge clk) begin
        #2;
        if (q_exp.size() > 0) begin
            logic [8:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if ({status, mem_ok} !== e) begin
                fails++;
                $display("FAIL %s status=%02h ok=%b expected status=%02h ok=%b",
                         t, status, mem_ok, e[8:1], e[0]);
            end
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(11'h000, 1'b1, "R1 reset state");
        step(0, 0, 1, 8'h8C, 0, 11'h000, 1'b1, "R7 status write without flag");
        idle(11'h000, 1'b1, "R7 no permit without flag");
        step(1, 0, 0, 8'h00, 0, 11'h000, 1'b1, "R3 set flag / R2 format");
        step(0, 1, 0, 8'h00, 0, 11'h000, 1'b1, "R3 clear flag");
        step(1, 1, 0, 8'h00, 0, 11'h000, 1'b1, "R3 clear wins");
        step(1, 0, 0, 8'h00, 0, 11'h000, 1'b1, "R3 set again");
        peek(11'h7FF, "R11 permit follows address");
        step(0, 0, 1, 8'hFF, 0, 11'h000, 1'b1, "R4 R5 R2 accepted write all ones");
        step(1, 0, 0, 8'h00, 0, 11'h000, 1'b1, "R3 set under full protect");
        idle(11'h000, 1'b1, "R9 full protect at 000");
        step(0, 0, 1, 8'h00, 0, 11'h000, 1'b0, "R8 R5 pin lock rejects");
        step(1, 0, 0, 8'h00, 0, 11'h000, 1'b1, "R3 set");
        step(0, 0, 1, 8'h84, 0, 11'h000, 1'b1, "R8 pin high accepts");
        step(1, 0, 0, 8'h00, 0, 11'h5FF, 1'b1, "R9 01 below boundary");
        idle(11'h600, 1'b1, "R9 01 at boundary");
        idle(11'h7FF, 1'b1, "R9 01 top");
        idle(11'h5FF, 1'b0, "R10 pin low keeps permit");
        idle(11'h600, 1'b0, "R10 pin low protected");
        peek(11'h000, "R11 permit low address");
        step(0, 0, 0, 8'h00, 1, 11'h000, 1'b1, "R6 memory write clears flag");
        step(1, 0, 0, 8'h00, 0, 11'h000, 1'b1, "R3 set");
        step(0, 0, 1, 8'h08, 0, 11'h000, 1'b1, "R4 write 10 clear lock");
        step(1, 0, 0, 8'h00, 0, 11'h3FF, 1'b1, "R9 10 below boundary");
        idle(11'h400, 1'b1, "R9 10 at boundary");
        step(0, 0, 1, 8'h0C, 0, 11'h000, 1'b0, "R8 lock off pin ignored");
        step(1, 0, 0, 8'h00, 0, 11'h000, 1'b0, "R9 11 protects 000");
        step(0, 0, 1, 8'h00, 0, 11'h000, 1'b0, "R8 clear protect, pin low");
        step(1, 0, 0, 8'h00, 0, 11'h7FF, 1'b1, "R9 00 top writable");
        step(0, 0, 1, 8'h72, 0, 11'h7FF, 1'b1, "R4 ignored data bits");
        idle(11'h7FF, 1'b1, "R7 no permit after status write");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule